// File: doc/BRIEF.md
# Controller/Datapath Test Access Wrapper

This block sits on the signals between a finite-state-machine controller and the datapath it steers. A small set of test pins chooses the mode. In functional operation the wrapper is transparent. The controller sees the datapath's status flags, the datapath takes the controller's control word, and the datapath's data outputs reach the primary outputs. In controller test, the controller's status inputs come from the datapath primary inputs. The controller's control word can then be read on the primary outputs. In datapath test, the control word and the extra test-only control lines of the datapath come from an on-chip test controller. The datapath's status flags can then be read on the primary outputs.

No extra chip pins are added for this access. The internal status and control signals share the datapath's own primary inputs and outputs through multiplexers. The mode decode is purely combinational, so the wrapper adds no register stage. It does not limit at-speed operation beyond one multiplexer level on each path. The controller, the datapath arithmetic and the test-plan source are outside the block and appear only as ports.

Top module: `tw_test_wrapper`

## Requirements
- R1: With all five test pins at 0, `ctl_si` equals `dp_ss`, `dp_ci` equals `fsm_cs`, `dp_aci` is 0, `po` equals `dp_do`, and `ctl_src_sel` and `ctl_hold` are 0.
- R2: Pin bit 0 selects controller test and pin bit 1 selects datapath test. When both are 1, the wrapper behaves exactly as in functional mode, so the two parts are never tested together.
- R3: In controller test (bit 0 = 1, bit 1 = 0), `ctl_si` equals the low `SS_W` bits of `dp_pi`. The upper primary-input bits are dropped.
- R4: In controller test, with pin bit 2 at 1, `po` equals `fsm_cs` zero-extended to `PO_W`. With pin bit 2 at 0, `po` equals `dp_do`.
- R5: In datapath test (bit 1 = 1, bit 0 = 0), `dp_ci` equals `tpg_cs` and `dp_aci` equals `tpg_acs`.
- R6: In datapath test, with pin bit 2 at 1, `po` equals `dp_ss` zero-extended to `PO_W`. With pin bit 2 at 0, `po` equals `dp_do`.
- R7: Outside datapath test, `dp_aci` is 0 for any `tpg_acs`, so every added test element of the datapath stays in its functional state.
- R8: `ctl_src_sel` follows pin bit 3 and `ctl_hold` follows pin bit 4 only in controller test. In every other mode both are 0.
- R9: In functional mode, pin bits 2, 3 and 4 have no effect on any output.
- R10: Every output responds to a change of pins or data within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tpin | input | 5 | Test pins: bit0 controller test, bit1 datapath test, bit2 observe select, bit3 state-source select, bit4 state hold |
| dp_pi | input | PI_W | Datapath primary inputs |
| fsm_cs | input | CS_W | Control word from the controller FSM |
| tpg_cs | input | CS_W | Control word from the test controller |
| tpg_acs | input | ACS_W | Test-only datapath control lines from the test controller |
| dp_ss | input | SS_W | Status flags from the datapath |
| dp_do | input | PO_W | Datapath data outputs |
| ctl_si | output | SS_W | Status inputs delivered to the controller |
| dp_ci | output | CS_W | Control word delivered to the datapath |
| dp_aci | output | ACS_W | Test-only control lines delivered to the datapath |
| po | output | PO_W | Datapath primary outputs |
| ctl_src_sel | output | 1 | State-register source select to the controller |
| ctl_hold | output | 1 | State-register hold to the controller |

## Verification
The bench builds the wrapper with PI_W=8, PO_W=8, SS_W=4, CS_W=6 and ACS_W=3. Both the status word and the control word are then narrower than the output word. This exposes the zero padding of the observation path. Because the primary inputs are wider than the status word, dropping the upper input bits can also be seen. A 3-bit test-only control field with nonzero stimulus shows whether the forcing to 0 works outside datapath test.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int PIN_N    = 5;
    localparam int PIN_CTL  = 0;
    localparam int PIN_DP   = 1;
    localparam int PIN_OBS  = 2;
    localparam int PIN_SRC  = 3;
    localparam int PIN_HOLD = 4;

    typedef enum logic [1:0] {
        TW_FUNC     = 2'd0,
        TW_CTL_TEST = 2'd1,
        TW_DP_TEST  = 2'd2
    } tw_mode_e;

    typedef struct packed {
        tw_mode_e mode;
        logic     obs_sel;
        logic     src_sel;
        logic     hold;
    } tw_dec_t;

endpackage

// File: rtl/tw_mode_decode.sv
module tw_mode_decode
    import tw_pkg::*;
(
    input  logic [PIN_N-1:0] tpin,
    output tw_dec_t          dec
);

    tw_dec_t dec_d;

    always_comb begin
        dec_d = '0;
        unique case ({tpin[PIN_DP], tpin[PIN_CTL]})
            2'b01:   dec_d.mode = TW_CTL_TEST;
            2'b10:   dec_d.mode = TW_DP_TEST;
            default: dec_d.mode = TW_FUNC;
        endcase
        if (dec_d.mode != TW_FUNC) begin
            dec_d.obs_sel = tpin[PIN_OBS];
        end
        if (dec_d.mode == TW_CTL_TEST) begin
            dec_d.src_sel = tpin[PIN_SRC];
            dec_d.hold    = tpin[PIN_HOLD];
        end
    end

    assign dec = dec_d;

endmodule

// File: rtl/tw_status_mux.sv
module tw_status_mux
    import tw_pkg::*;
#(
    parameter int PI_W = 8,
    parameter int SS_W = 4
) (
    input  tw_mode_e        mode,
    input  logic [PI_W-1:0] dp_pi,
    input  logic [SS_W-1:0] dp_ss,
    output logic [SS_W-1:0] ctl_si
);

    logic [SS_W-1:0] pi_slice;
    logic [SS_W-1:0] si_d;

    generate
        if (PI_W < SS_W) begin : g_bad_width
            $error("tw_status_mux: PI_W must be at least SS_W");
        end
    endgenerate

    assign pi_slice = dp_pi[SS_W-1:0];

    always_comb begin
        si_d = dp_ss;
        if (mode == TW_CTL_TEST) begin
            si_d = pi_slice;
        end
    end

    assign ctl_si = si_d;

    // R3
    always_comb begin
        if (mode == TW_CTL_TEST) begin
            si_from_pi_chk: assert (ctl_si == dp_pi[SS_W-1:0])
                else $error("status input not taken from primary inputs");
        end
    end

endmodule

// File: rtl/tw_ctl_mux.sv
module tw_ctl_mux
    import tw_pkg::*;
#(
    parameter int CS_W  = 6,
    parameter int ACS_W = 3
) (
    input  tw_mode_e         mode,
    input  logic [CS_W-1:0]  fsm_cs,
    input  logic [CS_W-1:0]  tpg_cs,
    input  logic [ACS_W-1:0] tpg_acs,
    output logic [CS_W-1:0]  dp_ci,
    output logic [ACS_W-1:0] dp_aci
);

    typedef struct packed {
        logic [CS_W-1:0]  ci;
        logic [ACS_W-1:0] aci;
    } ctl_t;

    ctl_t ctl_d;

    always_comb begin
        ctl_d.ci  = fsm_cs;
        ctl_d.aci = '0;
        if (mode == TW_DP_TEST) begin
            ctl_d.ci  = tpg_cs;
            ctl_d.aci = tpg_acs;
        end
    end

    assign dp_ci  = ctl_d.ci;
    assign dp_aci = ctl_d.aci;

    // R7
    always_comb begin
        if (mode != TW_DP_TEST) begin
            dft_off_chk: assert (dp_aci == '0)
                else $error("test-only control active outside datapath test");
        end
    end

    // R5
    always_comb begin
        if (mode == TW_DP_TEST) begin
            tpg_drive_chk: assert (dp_ci == tpg_cs && dp_aci == tpg_acs)
                else $error("datapath control not from test controller");
        end
    end

endmodule

// File: rtl/tw_obs_mux.sv
module tw_obs_mux
    import tw_pkg::*;
#(
    parameter int PO_W = 8,
    parameter int CS_W = 6,
    parameter int SS_W = 4
) (
    input  tw_mode_e        mode,
    input  logic            obs_sel,
    input  logic [PO_W-1:0] dp_do,
    input  logic [CS_W-1:0] fsm_cs,
    input  logic [SS_W-1:0] dp_ss,
    output logic [PO_W-1:0] po
);

    localparam int CS_PAD = PO_W - CS_W;
    localparam int SS_PAD = PO_W - SS_W;

    logic [PO_W-1:0] cs_wide;
    logic [PO_W-1:0] ss_wide;
    logic [PO_W-1:0] po_d;

    generate
        if (CS_PAD < 0 || SS_PAD < 0) begin : g_bad_width
            $error("tw_obs_mux: PO_W must cover CS_W and SS_W");
        end
        if (CS_PAD > 0) begin : g_cs_pad
            assign cs_wide = {{CS_PAD{1'b0}}, fsm_cs};
        end else begin : g_cs_flat
            assign cs_wide = fsm_cs[PO_W-1:0];
        end
        if (SS_PAD > 0) begin : g_ss_pad
            assign ss_wide = {{SS_PAD{1'b0}}, dp_ss};
        end else begin : g_ss_flat
            assign ss_wide = dp_ss[PO_W-1:0];
        end
    endgenerate

    always_comb begin
        po_d = dp_do;
        if (obs_sel) begin
            unique case (mode)
                TW_CTL_TEST: po_d = cs_wide;
                TW_DP_TEST:  po_d = ss_wide;
                default:     po_d = dp_do;
            endcase
        end
    end

    assign po = po_d;

    // R1
    always_comb begin
        if (mode == TW_FUNC) begin
            func_po_chk: assert (po == dp_do)
                else $error("primary outputs not transparent in functional mode");
        end
    end

    // R4
    always_comb begin
        if (mode == TW_CTL_TEST && obs_sel) begin
            ctl_obs_chk: assert (po[CS_W-1:0] == fsm_cs)
                else $error("control word not visible on primary outputs");
        end
    end

endmodule

// File: rtl/tw_test_wrapper.sv
module tw_test_wrapper
    import tw_pkg::*;
#(
    parameter int PI_W  = 8,
    parameter int PO_W  = 8,
    parameter int SS_W  = 4,
    parameter int CS_W  = 6,
    parameter int ACS_W = 3
) (
    input  logic [PIN_N-1:0] tpin,
    input  logic [PI_W-1:0]  dp_pi,
    input  logic [CS_W-1:0]  fsm_cs,
    input  logic [CS_W-1:0]  tpg_cs,
    input  logic [ACS_W-1:0] tpg_acs,
    input  logic [SS_W-1:0]  dp_ss,
    input  logic [PO_W-1:0]  dp_do,
    output logic [SS_W-1:0]  ctl_si,
    output logic [CS_W-1:0]  dp_ci,
    output logic [ACS_W-1:0] dp_aci,
    output logic [PO_W-1:0]  po,
    output logic             ctl_src_sel,
    output logic             ctl_hold
);

    tw_dec_t dec;

    tw_mode_decode u_dec (
        .tpin (tpin),
        .dec  (dec)
    );

    tw_status_mux #(.PI_W(PI_W), .SS_W(SS_W)) u_si (
        .mode   (dec.mode),
        .dp_pi  (dp_pi),
        .dp_ss  (dp_ss),
        .ctl_si (ctl_si)
    );

    tw_ctl_mux #(.CS_W(CS_W), .ACS_W(ACS_W)) u_ci (
        .mode    (dec.mode),
        .fsm_cs  (fsm_cs),
        .tpg_cs  (tpg_cs),
        .tpg_acs (tpg_acs),
        .dp_ci   (dp_ci),
        .dp_aci  (dp_aci)
    );

    tw_obs_mux #(.PO_W(PO_W), .CS_W(CS_W), .SS_W(SS_W)) u_po (
        .mode    (dec.mode),
        .obs_sel (dec.obs_sel),
        .dp_do   (dp_do),
        .fsm_cs  (fsm_cs),
        .dp_ss   (dp_ss),
        .po      (po)
    );

    assign ctl_src_sel = dec.src_sel;
    assign ctl_hold    = dec.hold;

    // R2
    always_comb begin
        if (tpin[PIN_CTL] && tpin[PIN_DP]) begin
            both_pins_func_chk: assert (dp_ci == fsm_cs && ctl_si == dp_ss && po == dp_do)
                else $error("both test pins set but wrapper not functional");
        end
    end

    // R8
    always_comb begin
        if (!(tpin[PIN_CTL] && !tpin[PIN_DP])) begin
            ctl_pins_gate_chk: assert (!ctl_src_sel && !ctl_hold)
                else $error("state-register controls leak outside controller test");
        end
    end

endmodule

// File: tb/sim_tw_test_wrapper.sv
module sim_tw_test_wrapper;

    localparam int PI_W  = 8;
    localparam int PO_W  = 8;
    localparam int SS_W  = 4;
    localparam int CS_W  = 6;
    localparam int ACS_W = 3;

    typedef struct packed {
        logic [4:0]       pins;
        logic [PI_W-1:0]  pi;
        logic [CS_W-1:0]  fsm;
        logic [CS_W-1:0]  tpg;
        logic [ACS_W-1:0] acs;
        logic [SS_W-1:0]  ss;
        logic [PO_W-1:0]  dout;
        logic [SS_W-1:0]  e_si;
        logic [CS_W-1:0]  e_ci;
        logic [ACS_W-1:0] e_aci;
        logic [PO_W-1:0]  e_po;
        logic [1:0]       e_sel;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h2B, 3'd0, 8'h3C, 2'b00},
        '{5'b11100, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h2B, 3'd0, 8'h3C, 2'b00},
        '{5'b00001, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h5, 6'h2B, 3'd0, 8'h3C, 2'b00},
        '{5'b00101, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h5, 6'h2B, 3'd0, 8'h2B, 2'b00},
        '{5'b11001, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h5, 6'h2B, 3'd0, 8'h3C, 2'b11},
        '{5'b01001, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h5, 6'h2B, 3'd0, 8'h3C, 2'b01},
        '{5'b00010, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h14, 3'd5, 8'h3C, 2'b00},
        '{5'b00110, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h14, 3'd5, 8'h09, 2'b00},
        '{5'b11010, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h14, 3'd5, 8'h3C, 2'b00},
        '{5'b00011, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h2B, 3'd0, 8'h3C, 2'b00},
        '{5'b11111, 8'hA5, 6'h2B, 6'h14, 3'd5, 4'h9, 8'h3C, 4'h9, 6'h2B, 3'd0, 8'h3C, 2'b00},
        '{5'b00101, 8'h3F, 6'h3F, 6'h01, 3'd2, 4'h6, 8'hC3, 4'hF, 6'h3F, 3'd0, 8'h3F, 2'b00},
        '{5'b00110, 8'h3F, 6'h3F, 6'h01, 3'd2, 4'h6, 8'hC3, 4'h6, 6'h01, 3'd2, 8'h06, 2'b00},
        '{5'b00000, 8'h3F, 6'h3F, 6'h01, 3'd2, 4'h6, 8'hC3, 4'h6, 6'h3F, 3'd0, 8'hC3, 2'b00}
    };

    logic             clk;
    logic             rst;
    logic [4:0]       tpin;
    logic [PI_W-1:0]  dp_pi;
    logic [CS_W-1:0]  fsm_cs;
    logic [CS_W-1:0]  tpg_cs;
    logic [ACS_W-1:0] tpg_acs;
    logic [SS_W-1:0]  dp_ss;
    logic [PO_W-1:0]  dp_do;
    logic [SS_W-1:0]  ctl_si;
    logic [CS_W-1:0]  dp_ci;
    logic [ACS_W-1:0] dp_aci;
    logic [PO_W-1:0]  po;
    logic             ctl_src_sel;
    logic             ctl_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    tw_test_wrapper #(
        .PI_W(PI_W), .PO_W(PO_W), .SS_W(SS_W), .CS_W(CS_W), .ACS_W(ACS_W)
    ) u0 (
        .tpin(tpin), .dp_pi(dp_pi), .fsm_cs(fsm_cs), .tpg_cs(tpg_cs),
        .tpg_acs(tpg_acs), .dp_ss(dp_ss), .dp_do(dp_do), .ctl_si(ctl_si),
        .dp_ci(dp_ci), .dp_aci(dp_aci), .po(po),
        .ctl_src_sel(ctl_src_sel), .ctl_hold(ctl_hold)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic string tag_of(int i);
        case (i)
            0, 13:  return "R1";
            1:      return "R9";
            2:      return "R3";
            3, 11:  return "R4";
            4, 5, 8: return "R8";
            6:      return "R5";
            7, 12:  return "R6";
            9, 10:  return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        tpin    = v.pins;
        dp_pi   = v.pi;
        fsm_cs  = v.fsm;
        tpg_cs  = v.tpg;
        tpg_acs = v.acs;
        dp_ss   = v.ss;
        dp_do   = v.dout;
    endtask

    task automatic check_all(input string tag, input vec_t v);
        check(tag, "ctl_si", 32'(ctl_si), 32'(v.e_si));
        check(tag, "dp_ci",  32'(dp_ci),  32'(v.e_ci));
        check(tag, "dp_aci", 32'(dp_aci), 32'(v.e_aci));
        check(tag, "po",     32'(po),     32'(v.e_po));
        check(tag, "sel",    32'({ctl_hold, ctl_src_sel}), 32'(v.e_sel));
    endtask

    initial begin
        vec_t z;
        z = '0;
        rst = 1'b1;
        apply(z);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, all pins and data at 0
        check_all("R1", z);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #2;
            check_all(tag_of(i), VEC[i]);
        end

        // R7: test-only controls held at 0 in controller test with nonzero source
        @(negedge clk);
        apply(VEC[2]);
        tpg_acs = 3'd7;
        #2;
        check("R7", "dp_aci", 32'(dp_aci), 32'd0);

        // R10: outputs follow a mid-cycle change with no clock edge
        @(posedge clk);
        #1;
        tpin  = 5'b00110;
        dp_ss = 4'hA;
        #1;
        check("R10", "po", 32'(po), 32'h0A);
        dp_ss = 4'h3;
        #1;
        check("R10", "po", 32'(po), 32'h03);
        tpin = 5'b00000;
        #1;
        check("R10", "po", 32'(po), 32'(dp_do));

        // R9: toggling observe/state pins in functional mode leaves outputs alone
        @(negedge clk);
        apply(VEC[0]);
        tpin = 5'b10100;
        #2;
        check_all("R9", VEC[0]);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule